// File: doc/BRIEF.md
# Simultaneous Multi-Channel Servo Pulse Generator

This block drives a bank of hobby servo outputs from position codes. A step counter splits time into frames. At the start of every frame each output goes high on the same clock, and each one drops once a minimum width plus its position code, counted in step ticks, has passed. A step tick fires once every `CLK_DIV` clocks. With the defaults (`CLK_DIV`=4 on a 3.4133 MHz clock, so a step of about 1.1718 µs, and a minimum of 785 steps), code 0 gives about 920 µs, mid-scale about 1520 µs and the top code about 2120 µs.

An upstream frame decoder presents new positions with a one-clock strobe once a frame has been validated. The codes are held and are applied only at the next frame boundary, so a pulse never changes width while it is running. If a set number of frame periods in a row go by with no strobe, the block enters failsafe. The pulses keep running so that the servos keep their torque. They use either the last good positions or a preset set of positions, as a select input chooses. Failsafe ends at the first frame boundary that follows a valid strobe.

Top module: `servo_pulse_bank`

## Requirements
- R1: After reset `failsafe_o` is 1 and every channel uses the mid-scale code 2^(POS_W-1) until the first frame boundary. The held positions also start at mid-scale.
- R2: A frame lasts `FRAME_STEPS*CLK_DIV` clocks. All bits of `pulse_o` go high together on the first clock of every frame, and none rises on any other clock.
- R3: In each frame a channel is high for exactly `(MIN_STEPS + code)*CLK_DIV` consecutive clocks, where code is the unsigned value latched for that channel at the frame boundary.
- R4: A strobe on `pos_vld_i` updates the held codes on any clock. Channel k takes bits `[k*POS_W +: POS_W]` of `pos_i`. The held codes take effect only at the next frame boundary.
- R5: When several strobes fall in one frame, the last one supplies the codes used in the next frame.
- R6: At a frame boundary that ends a frame with no strobe, the count of consecutive missed frames increases, saturating at 2^LOSS_W-1. Failsafe turns on when that count reaches `loss_lim_i`; the values 0 and 1 both mean a single missed frame is enough. Once on, failsafe stays on until R8 clears it.
- R7: While failsafe is on, `fs_sel_i`=1 (preset) makes the channels use the codes from `fs_pos_i`, packed as in R4. `fs_sel_i`=0 (hold) makes them use the held codes. Both inputs are sampled at the frame boundary.
- R8: At a frame boundary that ends a frame containing a strobe, `failsafe_o` goes to 0, the miss count clears, and the strobed codes are used.
- R9: A strobe on the last clock of a frame counts toward that frame. Its codes are used in the frame that starts on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the step tick is derived from it |
| rst | input | 1 | Synchronous active-high reset |
| pos_i | input | N_CH*POS_W | Packed position codes, channel k in bits [k*POS_W +: POS_W] |
| pos_vld_i | input | 1 | One-clock strobe: `pos_i` holds a validated frame |
| fs_pos_i | input | N_CH*POS_W | Preset failsafe codes, packed as `pos_i` |
| fs_sel_i | input | 1 | Failsafe policy: 1 uses preset codes, 0 holds the last codes |
| loss_lim_i | input | LOSS_W | Consecutive missed frames that engage failsafe |
| pulse_o | output | N_CH | Servo pulse outputs |
| failsafe_o | output | 1 | High while failsafe is engaged |

## Verification
Several assertions take for granted that `MIN_STEPS` is at least 1 and that `MIN_STEPS + 2^POS_W - 1` is below `FRAME_STEPS`. Under those conditions every output is high on the first step of a frame and low for at least one step before the frame ends. The rise-together and rise-only-at-step-zero checks depend on this, and the bench configuration (3 + 15 < 20) keeps within it. The failsafe checks take `pos_vld_i` as a strobe that is sampled only at clock edges. The bench drives it for exactly one clock, always from the falling edge. Every code from 0 to 15 is swept on every channel. The strobe is placed at the start, middle and last clock of a frame, and the loss limit is set to 0, 2 and the policy changed while failsafe is on.

// File: rtl/servo_pkg.sv
package servo_pkg;

    typedef enum logic {
        FS_HOLD   = 1'b0,
        FS_PRESET = 1'b1
    } fs_policy_e;

    // Width of a down-counter index, at least one bit.
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/servo_step_timer.sv
module servo_step_timer #(
    parameter int CLK_DIV     = 4,
    parameter int FRAME_STEPS = 12000,
    parameter int STEP_W      = servo_pkg::idx_w(FRAME_STEPS)
) (
    input  logic              clk,
    input  logic              rst,
    output logic [STEP_W-1:0] step_cnt_o,
    output logic              frame_end_o
);
    localparam int              DIV_W = servo_pkg::idx_w(CLK_DIV);
    localparam logic [STEP_W-1:0] LAST = STEP_W'(FRAME_STEPS - 1);

    logic              tick;
    logic [STEP_W-1:0] step_q;

    generate
        if (CLK_DIV == 1) begin : g_nodiv
            assign tick = 1'b1;
        end else begin : g_div
            localparam logic [DIV_W-1:0] DLAST = DIV_W'(CLK_DIV - 1);
            logic [DIV_W-1:0] div_q;
            always_ff @(posedge clk) begin
                if (rst)              div_q <= '0;
                else if (div_q == DLAST) div_q <= '0;
                else                  div_q <= div_q + 1'b1;
            end
            assign tick = (div_q == DLAST);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)       step_q <= '0;
        else if (tick) step_q <= (step_q == LAST) ? '0 : step_q + 1'b1;
    end

    assign step_cnt_o  = step_q;
    assign frame_end_o = tick & (step_q == LAST);

    // R2
    wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
        frame_end_o |=> (step_cnt_o == '0));
endmodule

// File: rtl/servo_loss_mon.sv
module servo_loss_mon #(
    parameter int LOSS_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bnd_i,
    input  logic              vld_i,
    input  logic [LOSS_W-1:0] lim_i,
    output logic              fs_next_o,
    output logic              fs_o
);
    localparam logic [LOSS_W-1:0] MISS_MAX = '1;

    logic              got_q, got_any, fs_q;
    logic [LOSS_W-1:0] miss_q, miss_inc, eff_lim;

    assign got_any  = got_q | vld_i;
    assign miss_inc = (miss_q == MISS_MAX) ? MISS_MAX : miss_q + 1'b1;
    assign eff_lim  = (lim_i == '0) ? LOSS_W'(1) : lim_i;
    assign fs_next_o = got_any ? 1'b0 : (fs_q | (miss_inc >= eff_lim));

    always_ff @(posedge clk) begin
        if (rst) begin
            got_q  <= 1'b0;
            miss_q <= '0;
            fs_q   <= 1'b1;
        end else if (bnd_i) begin
            got_q  <= 1'b0;
            miss_q <= got_any ? '0 : miss_inc;
            fs_q   <= fs_next_o;
        end else if (vld_i) begin
            got_q  <= 1'b1;
        end
    end

    assign fs_o = fs_q;

    // R6
    fs_only_at_bnd_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(fs_q) |-> $past(bnd_i));
    // R8
    fs_clear_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(fs_q) |-> ($past(got_q) || $past(vld_i)));
endmodule

// File: rtl/servo_chan.sv
module servo_chan #(
    parameter int POS_W     = 10,
    parameter int STEP_W    = 14,
    parameter int MIN_STEPS = 785
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [POS_W-1:0]  lat_i,
    input  logic [STEP_W-1:0] step_cnt_i,
    output logic              pulse_o
);
    localparam int CMP_W = STEP_W + 1;

    logic [CMP_W-1:0] thr;

    assign thr     = CMP_W'(MIN_STEPS) + CMP_W'(lat_i);
    assign pulse_o = ({1'b0, step_cnt_i} < thr);

    // R2
    rise_at_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pulse_o) |-> (step_cnt_i == '0));
    // R3
    min_width_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(pulse_o) |-> (CMP_W'(step_cnt_i) >= CMP_W'(MIN_STEPS)));
endmodule

// File: rtl/servo_pulse_bank.sv
module servo_pulse_bank #(
    parameter int N_CH        = 8,
    parameter int POS_W       = 10,
    parameter int CLK_DIV     = 4,
    parameter int MIN_STEPS   = 785,
    parameter int FRAME_STEPS = 12000,
    parameter int LOSS_W      = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [N_CH*POS_W-1:0]   pos_i,
    input  logic                    pos_vld_i,
    input  logic [N_CH*POS_W-1:0]   fs_pos_i,
    input  logic                    fs_sel_i,
    input  logic [LOSS_W-1:0]       loss_lim_i,
    output logic [N_CH-1:0]         pulse_o,
    output logic                    failsafe_o
);
    import servo_pkg::*;

    localparam int              STEP_W = idx_w(FRAME_STEPS);
    localparam logic [POS_W-1:0] MID   = POS_W'(1 << (POS_W - 1));

    logic [STEP_W-1:0]       step_cnt;
    logic                    frame_end, fs_next;
    logic [N_CH*POS_W-1:0]   held_q, lat_q, held_nx;
    fs_policy_e              policy;

    servo_step_timer #(.CLK_DIV(CLK_DIV), .FRAME_STEPS(FRAME_STEPS), .STEP_W(STEP_W)) u_tmr (
        .clk(clk), .rst(rst), .step_cnt_o(step_cnt), .frame_end_o(frame_end));

    servo_loss_mon #(.LOSS_W(LOSS_W)) u_loss (
        .clk(clk), .rst(rst), .bnd_i(frame_end), .vld_i(pos_vld_i),
        .lim_i(loss_lim_i), .fs_next_o(fs_next), .fs_o(failsafe_o));

    assign policy  = fs_policy_e'(fs_sel_i);
    assign held_nx = pos_vld_i ? pos_i : held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= {N_CH{MID}};
            lat_q  <= {N_CH{MID}};
        end else begin
            held_q <= held_nx;
            if (frame_end)
                lat_q <= (fs_next && policy == FS_PRESET) ? fs_pos_i : held_nx;
        end
    end

    generate
        for (genvar k = 0; k < N_CH; k++) begin : g_ch
            servo_chan #(.POS_W(POS_W), .STEP_W(STEP_W), .MIN_STEPS(MIN_STEPS)) u_ch (
                .clk(clk), .rst(rst),
                .lat_i(lat_q[k*POS_W +: POS_W]),
                .step_cnt_i(step_cnt),
                .pulse_o(pulse_o[k]));
        end
    endgenerate

    // R2
    rise_together_chk: assert property (@(posedge clk) disable iff (rst)
        (|(pulse_o & ~$past(pulse_o))) |-> (&pulse_o));
    // R4
    lat_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (step_cnt != '0) |-> $stable(pulse_o & ~$past(pulse_o)) || !(|(pulse_o & ~$past(pulse_o))));
endmodule

// File: tb/sim_servo_pulse_bank.sv
module sim_servo_pulse_bank;
    localparam int N = 4, PW = 4, DIV = 2, MINS = 3, FRS = 20, LW = 3;
    localparam int F = FRS * DIV;

    logic clk = 1'b0, rst = 1'b1;
    logic [N*PW-1:0] pos = '0, fsp = '0;
    logic vld = 1'b0, sel = 1'b0;
    logic [LW-1:0] lim = '0;
    logic [N-1:0] pulse;
    logic fsafe;

    int total = 0, bad = 0;
    bit done = 0;
    int m_held[N], m_lat[N];
    int m_fs, m_miss;

    always #5 clk = ~clk;

    servo_pulse_bank #(.N_CH(N), .POS_W(PW), .CLK_DIV(DIV), .MIN_STEPS(MINS),
                       .FRAME_STEPS(FRS), .LOSS_W(LW)) u0 (
        .clk(clk), .rst(rst), .pos_i(pos), .pos_vld_i(vld), .fs_pos_i(fsp),
        .fs_sel_i(sel), .loss_lim_i(lim), .pulse_o(pulse), .failsafe_o(fsafe));

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Runs one frame from its first clock; s1/s2 = sample index of a strobe (-1 none).
    task automatic frame(input string req, input int s1, input logic [N*PW-1:0] d1,
                         input int s2, input logic [N*PW-1:0] d2);
        int hi[N];
        int late_rise = 0;
        bit got = 0;
        logic [N-1:0] prev = '0;
        for (int c = 0; c < N; c++) hi[c] = 0;
        chk({req, " failsafe_o at frame start (R6 R8)"}, int'(fsafe), m_fs);
        chk("R2 all channels high on first clock", int'(&pulse), 1);
        for (int i = 0; i < F; i++) begin
            for (int c = 0; c < N; c++) if (pulse[c]) hi[c]++;
            if (i > 0 && ((pulse & ~prev) != '0)) late_rise++;
            prev = pulse;
            vld = 1'b0;
            if (i == s1) begin
                pos = d1; vld = 1'b1; got = 1;
                for (int c = 0; c < N; c++) m_held[c] = int'(d1[c*PW +: PW]);
            end else if (i == s2) begin
                pos = d2; vld = 1'b1; got = 1;
                for (int c = 0; c < N; c++) m_held[c] = int'(d2[c*PW +: PW]);
            end
            @(negedge clk);
        end
        vld = 1'b0;
        chk("R2 no rise after frame start", late_rise, 0);
        for (int c = 0; c < N; c++)
            chk({req, " R3 width"}, hi[c], (MINS + m_lat[c]) * DIV);
        if (got) begin
            m_miss = 0; m_fs = 0;
        end else begin
            if (m_miss < (1 << LW) - 1) m_miss++;
            if (m_miss >= ((lim == '0) ? 1 : int'(lim))) m_fs = 1;
        end
        for (int c = 0; c < N; c++)
            m_lat[c] = (m_fs == 1 && sel) ? int'(fsp[c*PW +: PW]) : m_held[c];
    endtask

    function automatic logic [N*PW-1:0] pack(input int a, input int b, input int c, input int d);
        return {PW'(d), PW'(c), PW'(b), PW'(a)};
    endfunction

    initial begin
        for (int c = 0; c < N; c++) begin m_held[c] = 8; m_lat[c] = 8; end
        m_fs = 1; m_miss = 0;
        lim = 3'd2; sel = 1'b0; fsp = pack(1, 2, 3, 4);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state, mid-scale width, failsafe on
        chk("R1 failsafe after reset", int'(fsafe), 1);
        frame("R1 mid-scale", -1, '0, -1, '0);
        // R4 strobe applied at next boundary; R8 clears failsafe
        frame("R4", 5, pack(0, 5, 10, 15), -1, '0);
        frame("R8", -1, '0, -1, '0);
        // R3 sweep every code on every channel
        for (int k = 0; k < 16; k++)
            frame("R3 sweep", 10, pack(k, (k + 5) % 16, (k + 10) % 16, 15 - k), -1, '0);
        // R5 last strobe wins
        frame("R5", 3, pack(1, 1, 1, 1), 30, pack(9, 7, 5, 3));
        frame("R5", -1, '0, -1, '0);
        // R9 strobe on last clock
        frame("R9", F - 1, pack(14, 0, 6, 11), -1, '0);
        // R6 loss limit 2, R7 preset policy
        sel = 1'b1;
        frame("R9 applied", -1, '0, -1, '0);
        frame("R6 second miss", -1, '0, -1, '0);
        frame("R7 preset", -1, '0, -1, '0);
        sel = 1'b0;
        frame("R7 hold", -1, '0, -1, '0);
        frame("R7 hold kept", 2, pack(2, 4, 6, 8), -1, '0);
        // R8 clear, then R6 with limit 0
        lim = '0; sel = 1'b1;
        frame("R8 cleared", -1, '0, -1, '0);
        frame("R6 limit zero", -1, '0, -1, '0);
        frame("R6 preset in use", 0, pack(3, 3, 3, 3), -1, '0);
        frame("R8 final", -1, '0, -1, '0);
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule